// File: doc/BRIEF.md
# Machine-Mode Trap and Timer Controller

This unit holds the machine-mode control and status registers of a small 32-bit RISC-V core. It also holds a free-running 64-bit cycle timer with a compare register, and it sequences hardware trap entry and trap return. The pipeline sends it CSR commands for reading, writing, setting bits and clearing bits. It also sends the current PC and single-cycle indications of an environment call or a trap return, and an external interrupt line comes in from outside. The unit answers in the same cycle with CSR read data and a PC redirect request.

Interrupts are decided combinationally. If the global enable, the per-source enable and the pending bit are all set, the redirect is raised at once and the register updates take effect on the next clock edge. Software reaches the timer registers through a small word-addressed register bus. Reads from this bus are combinational, and writes take effect on the clock edge.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the following registers read zero: status, enable, epc, cause and trap vector. The timer reads zero and the compare register reads all ones. No redirect is raised while the unit is idle.
- R2: CSR addresses are status 0x300, enable 0x304, trap vector 0x305, epc 0x341, cause 0x342 and pending 0x344. With csr_en high, op 2'b01 writes, 2'b10 sets bits and 2'b11 clears bits. Op 2'b00 leaves the register unchanged. csr_rdata always shows the value the register held before the command.
- R3: Only bits 3 (global enable) and 7 (previous enable) of the status register can be written. Only bits 7 (timer) and 11 (external) of the enable register can be written. The pending register ignores writes: its bit 7 shows the timer pending state and its bit 11 shows ext_irq.
- R4: The timer increments by one on every clock edge after reset. Bus word 0 reads the timer's low half and word 1 its high half. Words 2 and 3 are the low and high halves of the compare register, and a write to either takes effect on the next edge.
- R5: The timer interrupt is pending exactly when the timer value is greater than or equal to the compare value.
- R6: An interrupt is taken only when the global enable, the matching enable bit and the matching pending bit are all set. When external and timer are both ready, the external interrupt wins.
- R7: On a trap, redirect rises in the same cycle, with redirect_pc set to the trap vector with its low two bits cleared. At the next edge the following updates occur: epc takes pc, the previous enable takes the global enable, and the global enable clears. The cause register becomes 0x8000000B for an external interrupt, 0x80000007 for a timer interrupt and 0x0000000B for an environment call.
- R8: On mret, redirect rises with redirect_pc equal to epc. At the next edge the global enable takes the previous enable and the previous enable is set.
- R9: An interrupt taken in the same cycle as an environment call or a CSR write takes precedence. The trap records cause and epc for the interrupt, with epc set to that cycle's pc, and the CSR write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | CSR command valid |
| csr_op | input | 2 | CSR operation: read-only, write, set, clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write or mask operand |
| csr_rdata | output | 32 | Value of the addressed CSR before the command |
| ext_irq | input | 1 | External interrupt request level |
| ecall | input | 1 | Environment call in the current instruction |
| mret | input | 1 | Trap return in the current instruction |
| pc | input | 32 | PC of the current instruction |
| redirect | output | 1 | PC redirect request |
| redirect_pc | output | 32 | Redirect target |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 2 | Register bus word select |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data |

## Verification
The assertions assume that the pipeline never raises ecall and mret in the same cycle. They also assume that reset is held low from time zero, so that the first sampled history belongs to reset. The bench drives ecall and mret one at a time, always from reset. Where a trap and another command share a cycle, that cycle carries an interrupt, an environment call and a CSR write, which is exactly the overlap that the precedence rule covers.

// File: rtl/mtrap_unit.sv
module mtrap_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_en,
  input  logic [1:0]  csr_op,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        ext_irq,
  input  logic        ecall,
  input  logic        mret,
  input  logic [31:0] pc,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam logic [11:0] A_STATUS = 12'h300, A_ENABLE = 12'h304, A_VEC = 12'h305;
  localparam logic [11:0] A_EPC = 12'h341, A_CAUSE = 12'h342, A_PEND = 12'h344;

  logic        g_en, g_prev, en_tmr, en_ext;
  logic [31:0] epc, cause, tvec;
  logic [63:0] ticks, cmp;

  wire tmr_pend = ticks >= cmp;
  wire take_ext = g_en & en_ext & ext_irq;
  wire take_tmr = g_en & en_tmr & tmr_pend & ~take_ext;
  wire irq      = take_ext | take_tmr;
  wire trap     = irq | ecall;
  wire do_ret   = mret & ~trap;
  wire do_csr   = csr_en & (csr_op != 2'b00) & ~irq;

  wire [31:0] status_v = {24'd0, g_prev, 3'd0, g_en, 3'd0};
  wire [31:0] enable_v = {20'd0, en_ext, 3'd0, en_tmr, 7'd0};
  wire [31:0] pend_v   = {20'd0, ext_irq, 3'd0, tmr_pend, 7'd0};

  always_comb begin
    case (csr_addr)
      A_STATUS: csr_rdata = status_v;
      A_ENABLE: csr_rdata = enable_v;
      A_VEC:    csr_rdata = tvec;
      A_EPC:    csr_rdata = epc;
      A_CAUSE:  csr_rdata = cause;
      A_PEND:   csr_rdata = pend_v;
      default:  csr_rdata = 32'd0;
    endcase
  end

  logic [31:0] nv;
  always_comb begin
    case (csr_op)
      2'b01:   nv = csr_wdata;
      2'b10:   nv = csr_rdata | csr_wdata;
      2'b11:   nv = csr_rdata & ~csr_wdata;
      default: nv = csr_rdata;
    endcase
  end

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = ticks[31:0];
      2'd1: bus_rdata = ticks[63:32];
      2'd2: bus_rdata = cmp[31:0];
      default: bus_rdata = cmp[63:32];
    endcase
  end

  assign redirect    = trap | mret;
  assign redirect_pc = trap ? {tvec[31:2], 2'b00} : epc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_en <= 1'b0; g_prev <= 1'b0; en_tmr <= 1'b0; en_ext <= 1'b0;
      epc <= '0; cause <= '0; tvec <= '0;
      ticks <= '0; cmp <= '1;
    end else begin
      ticks <= ticks + 64'd1;
      if (bus_we && bus_addr == 2'd2) cmp[31:0]  <= bus_wdata;
      if (bus_we && bus_addr == 2'd3) cmp[63:32] <= bus_wdata;
      if (do_csr) begin
        case (csr_addr)
          A_STATUS: begin g_en <= nv[3]; g_prev <= nv[7]; end
          A_ENABLE: begin en_tmr <= nv[7]; en_ext <= nv[11]; end
          A_VEC:    tvec  <= nv;
          A_EPC:    epc   <= nv;
          A_CAUSE:  cause <= nv;
          default: ;
        endcase
      end
      if (trap) begin
        epc    <= pc;
        cause  <= take_ext ? 32'h8000_000B : take_tmr ? 32'h8000_0007 : 32'h0000_000B;
        g_prev <= g_en;
        g_en   <= 1'b0;
      end else if (do_ret) begin
        g_en   <= g_prev;
        g_prev <= 1'b1;
      end
    end
  end

  assert_time_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ticks == $past(ticks) + 64'd1);
  assert_trap_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !g_en && g_prev == $past(g_en));
  assert_vec_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ecall || irq) |-> redirect && redirect_pc[1:0] == 2'b00);
  assert_ret_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !ecall && !irq) |=> g_en == $past(g_prev) && g_prev);
  assert_ext_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_ext |=> cause == 32'h8000_000B);
  assert_quiet_when_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!g_en && !ecall && !mret) |-> !redirect);
endmodule

// File: tb/sim_mtrap_unit.sv
module sim_mtrap_unit;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_en = 0, ext_irq = 0, ecall = 0, mret = 0, bus_we = 0;
  logic [1:0] csr_op = 0, bus_addr = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, pc = 0, bus_wdata = 0;
  logic [31:0] csr_rdata, redirect_pc, bus_rdata;
  logic redirect;

  always #(PER/2) clk = ~clk;

  mtrap_unit u0 (.clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ext_irq(ext_irq), .ecall(ecall), .mret(mret), .pc(pc),
    .redirect(redirect), .redirect_pc(redirect_pc), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  typedef struct { string req; int sel; logic [31:0] exp; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] tick = 0;

  always @(posedge clk) if (!rst_n) tick <= 0; else tick <= tick + 1;

  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      case (it.sel)
        0: got = csr_rdata;
        1: got = {31'd0, redirect};
        2: got = redirect_pc;
        default: got = bus_rdata;
      endcase
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d got=%h exp=%h", it.req, it.sel, got, it.exp);
      end
    end
  end

  task automatic push(string r, int s, logic [31:0] e);
    item_t it; it.req = r; it.sel = s; it.exp = e; q.push_back(it);
  endtask
  task automatic cyc();
    @(posedge clk); #1;
    csr_en = 0; csr_op = 0; ecall = 0; mret = 0; bus_we = 0;
  endtask
  task automatic csr_wr(logic [11:0] a, logic [1:0] op, logic [31:0] d);
    csr_en = 1; csr_op = op; csr_addr = a; csr_wdata = d; cyc();
  endtask
  task automatic csr_chk(string r, logic [11:0] a, logic [31:0] e);
    csr_en = 1; csr_op = 0; csr_addr = a; push(r, 0, e); cyc();
  endtask
  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d; cyc();
  endtask
  task automatic bus_chk(string r, logic [1:0] a, logic [31:0] e);
    bus_addr = a; push(r, 3, e); cyc();
  endtask

  initial begin
    #(PER * 20000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] tgt;
    cyc(); cyc();
    // R1 reset state
    push("R1", 1, 0);
    csr_chk("R1", 12'h300, 0);
    csr_chk("R1", 12'h342, 0);
    csr_chk("R1", 12'h305, 0);
    bus_chk("R1", 2'd2, 32'hFFFF_FFFF);
    bus_chk("R1", 2'd3, 32'hFFFF_FFFF);
    bus_chk("R1", 2'd0, 0);
    rst_n = 1;
    cyc();
    // R4 timer counting
    bus_chk("R4", 2'd0, tick);
    repeat (5) cyc();
    bus_chk("R4", 2'd0, tick);
    bus_chk("R4", 2'd1, 0);
    // R2 operations
    csr_wr(12'h305, 2'b01, 32'h100);
    csr_en = 1; csr_op = 2'b10; csr_addr = 12'h305; csr_wdata = 32'h3;
    push("R2", 0, 32'h100); cyc();
    csr_chk("R2", 12'h305, 32'h103);
    csr_wr(12'h305, 2'b11, 32'h1);
    csr_chk("R2", 12'h305, 32'h102);
    csr_en = 1; csr_op = 2'b00; csr_addr = 12'h305; csr_wdata = 32'hFFFF; cyc();
    csr_chk("R2", 12'h305, 32'h102);
    // R3 masks
    csr_wr(12'h300, 2'b01, 32'hFFFF_FFFF);
    csr_chk("R3", 12'h300, 32'h88);
    csr_wr(12'h300, 2'b01, 0);
    csr_wr(12'h304, 2'b01, 32'hFFFF_FFFF);
    csr_chk("R3", 12'h304, 32'h880);
    csr_wr(12'h304, 2'b01, 0);
    csr_wr(12'h344, 2'b01, 32'hFFFF_FFFF);
    csr_chk("R3", 12'h344, 0);
    // R7 ecall
    csr_wr(12'h300, 2'b01, 32'h8);
    pc = 32'h40; ecall = 1; push("R7", 1, 1); push("R7", 2, 32'h100); cyc();
    csr_chk("R7", 12'h341, 32'h40);
    csr_chk("R7", 12'h342, 32'hB);
    csr_chk("R7", 12'h300, 32'h80);
    // R8 mret
    mret = 1; push("R8", 1, 1); push("R8", 2, 32'h40); cyc();
    csr_chk("R8", 12'h300, 32'h88);
    // R6 gating by per-source enable, then external trap
    ext_irq = 1;
    push("R6", 1, 0);
    csr_chk("R3", 12'h344, 32'h800);
    csr_wr(12'h304, 2'b01, 32'h800);
    pc = 32'h80; push("R6", 1, 1); push("R7", 2, 32'h100); cyc();
    push("R6", 1, 0);
    csr_chk("R7", 12'h342, 32'h8000_000B);
    csr_chk("R7", 12'h341, 32'h80);
    ext_irq = 0;
    csr_wr(12'h304, 2'b01, 0);
    mret = 1; push("R8", 2, 32'h80); cyc();
    // R5 compare threshold
    bus_wr(2'd3, 0);
    tgt = tick + 30;
    bus_wr(2'd2, tgt);
    bus_chk("R4", 2'd2, tgt);
    while (tick < tgt - 1) cyc();
    csr_chk("R5", 12'h344, 0);
    csr_chk("R5", 12'h344, 32'h80);
    // R6 priority external over timer
    ext_irq = 1;
    csr_wr(12'h304, 2'b01, 32'h880);
    pc = 32'hC0; push("R6", 1, 1); cyc();
    csr_chk("R6", 12'h342, 32'h8000_000B);
    ext_irq = 0;
    mret = 1; push("R8", 2, 32'hC0); cyc();
    pc = 32'hD0; push("R6", 1, 1); push("R7", 2, 32'h100); cyc();
    csr_chk("R7", 12'h342, 32'h8000_0007);
    csr_chk("R7", 12'h341, 32'hD0);
    // R9 interrupt beats ecall and CSR write
    bus_wr(2'd3, 32'hFFFF_FFFF);
    ext_irq = 1;
    csr_wr(12'h300, 2'b01, 32'h8);
    csr_en = 1; csr_op = 2'b01; csr_addr = 12'h305; csr_wdata = 32'h200;
    ecall = 1; pc = 32'h300;
    push("R9", 2, 32'h100); cyc();
    ext_irq = 0;
    csr_chk("R9", 12'h342, 32'h8000_000B);
    csr_chk("R9", 12'h341, 32'h300);
    csr_chk("R9", 12'h305, 32'h102);
    cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule